// File: doc/BRIEF.md
# Masked Vector Lane Execution Unit

This unit runs one integer vector instruction at a time across a long run of elements held in an external element store, processing one element per clock through a pipelined lane. A pulse on `start` hands it an opcode, three register numbers, a scalar operand, a mask-enable flag and a total element count. An internal sequencer splits that count into strips of at most `MVL` elements. The first strip is the leftover piece (count modulo `MVL`), and every later strip is full length. The strip base index advances by the length of the strip just finished. Inside a strip, only the first `VL` elements are issued, where `VL` is the strip length held in an internal length register.

A not-equal compare against the scalar writes a per-position mask register instead of the store. A later instruction issued with `mask_en` high writes back only the positions whose mask bit is 1. Disabled positions leave the store untouched but still use their issue slot. The mask is indexed by the position inside the current strip, so every strip of a masked instruction reuses the same mask. `done` pulses once when the instruction has fully retired.

The controller is a five-state machine. IDLE waits for `start`. STRIP loads the next strip length, base and remainder. ISSUE sends one element per clock. DRAIN waits for the lane pipeline to empty. FIN raises `done` for one cycle. The transitions are as follows:
- IDLE→STRIP on `start`.
- STRIP→ISSUE when the strip length is non-zero.
- STRIP→STRIP when a zero-length strip is skipped and elements remain.
- STRIP→FIN when a zero-length strip leaves nothing to do.
- ISSUE→DRAIN after the last element of the strip is issued.
- DRAIN→STRIP when the pipeline is empty and elements remain.
- DRAIN→FIN when the pipeline is empty and no elements remain.
- FIN→IDLE unconditionally.

Top module: `vlu_top`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are low, and every mask bit is 1, so a masked instruction issued before any compare writes every element.
- R2: `start` is taken only in IDLE, where it latches opcode, registers, scalar, `mask_en` and count. A `start` while `busy` is high changes nothing about the instruction in flight.
- R3: For a total count n, the first strip covers n mod `MVL` elements at indices 0 upward, and each later strip covers `MVL` elements starting where the previous one ended. Store indices n and above are never written.
- R4: A strip of computed length zero (n a multiple of `MVL`, including n = 0) makes no writes and is skipped. For n = 0 the instruction still finishes with a `done` pulse.
- R5: Opcodes (3-bit `op`) use two's-complement arithmetic truncated to `DATA_W` bits. Opcode 0 gives a+b, 1 gives a−b, 2 gives a+scalar, 3 gives a−scalar and 4 gives a×scalar. Here a is element i of register `vs1` and b is element i of register `vs2`, and the result goes to element i of `vd`.
- R6: Opcode 5 (compare-not-equal) sets mask bit p to (a ≠ scalar) for each strip position p it processes, leaves other mask bits unchanged, ignores `mask_en` and writes nothing to the store.
- R7: With `mask_en` = 1, an element at strip position p is written only if mask bit p is 1, and otherwise keeps its old value. With `mask_en` = 0, every element below n is written.
- R8: Within a strip, elements issue one per clock, so an unmasked single strip of length L writes on L consecutive cycles.
- R9: `done` is high for exactly one cycle, later than the final write of the instruction, and no write occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken in IDLE only) |
| op | input | 3 | Opcode, encoding in R5/R6 |
| mask_en | input | 1 | Gate write-back by the mask register |
| vd | input | REG_W | Destination register number |
| vs1 | input | REG_W | First source register number |
| vs2 | input | REG_W | Second source register number |
| scalar | input | DATA_W | Scalar operand |
| total_len | input | LEN_W | Total element count n |
| rd_reg_a | output | REG_W | Read port A register number |
| rd_reg_b | output | REG_W | Read port B register number |
| rd_idx | output | IDX_W | Element index for both read ports |
| rd_data_a | input | DATA_W | Read data A, same cycle as address |
| rd_data_b | input | DATA_W | Read data B, same cycle as address |
| wr_en | output | 1 | Element write strobe |
| wr_reg | output | REG_W | Write register number |
| wr_idx | output | IDX_W | Write element index |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | High outside IDLE |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the strip boundary cases: a count below `MVL`, exactly `MVL`, an exact multiple with a zero-length leading strip, a count with a short leftover strip followed by full strips, and zero. A sequencer that got the remainder order wrong, or failed to skip empty strips, would write the wrong indices, write past n, or hang without `done`. Masking is tested by a compare across two strips followed by masked instructions, and by a masked instruction straight after reset. A design that indexed the mask by store index, let the compare write data, or reset the mask to zero would change the wrong elements. A stray `start` in mid-flight and the `done` pulse width catch a controller that relatches or holds `done` while writes are still pending.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_VV   = 3'd0,
        OP_SUB_VV   = 3'd1,
        OP_ADD_VS   = 3'd2,
        OP_SUB_VS   = 3'd3,
        OP_MUL_VS   = 3'd4,
        OP_CMPNE_VS = 3'd5
    } vop_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_STRIP = 3'd1,
        S_ISSUE = 3'd2,
        S_DRAIN = 3'd3,
        S_FIN   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/vlu_strip_seq.sv
// Strip sequencer: leftover piece first, then full-length strips.
module vlu_strip_seq #(
    parameter int MVL   = 64,
    parameter int LEN_W = 9,
    parameter int VL_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] total_len,
    input  logic             take,
    output logic [VL_W-1:0]  strip_len,
    output logic [VL_W-1:0]  vl_q,
    output logic [LEN_W-1:0] base_q,
    output logic [LEN_W-1:0] rem_q
);
    localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

    logic             first_q;
    logic [LEN_W-1:0] next_base_q;

    always_comb begin
        strip_len = first_q ? VL_W'(rem_q % MVL_L) : VL_W'(MVL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= 1'b0;
            next_base_q <= '0;
            base_q      <= '0;
            rem_q       <= '0;
            vl_q        <= '0;
        end else if (load) begin
            first_q     <= 1'b1;
            next_base_q <= '0;
            rem_q       <= total_len;
        end else if (take) begin
            first_q     <= 1'b0;
            base_q      <= next_base_q;
            next_base_q <= next_base_q + LEN_W'(strip_len);
            rem_q       <= rem_q - LEN_W'(strip_len);
            vl_q        <= strip_len;
        end
    end
endmodule

// File: rtl/vlu_lane_pipe.sv
// One-element-per-clock integer lane with LAT register stages.
module vlu_lane_pipe
    import vlu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int POS_W  = 6,
    parameter int IDX_W  = 8,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  vop_e              in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_s,
    input  logic [POS_W-1:0]  in_pos,
    input  logic [IDX_W-1:0]  in_idx,
    output logic              out_valid,
    output logic              out_cmp,
    output logic [POS_W-1:0]  out_pos,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_data,
    output logic              pipe_busy
);
    typedef struct packed {
        logic              valid;
        logic              cmp;
        logic [POS_W-1:0]  pos;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t stage_in;
    stage_t st [LAT];

    always_comb begin
        stage_in.valid = in_valid;
        stage_in.cmp   = (in_op == OP_CMPNE_VS);
        stage_in.pos   = in_pos;
        stage_in.idx   = in_idx;
        unique case (in_op)
            OP_ADD_VV:   stage_in.data = in_a + in_b;
            OP_SUB_VV:   stage_in.data = in_a - in_b;
            OP_ADD_VS:   stage_in.data = in_a + in_s;
            OP_SUB_VS:   stage_in.data = in_a - in_s;
            OP_MUL_VS:   stage_in.data = in_a * in_s;
            OP_CMPNE_VS: stage_in.data = {{(DATA_W-1){1'b0}}, (in_a != in_s)};
            default:     stage_in.data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) st[k] <= '0;
        end else begin
            st[0] <= stage_in;
            for (int k = 1; k < LAT; k++) st[k] <= st[k-1];
        end
    end

    always_comb begin
        pipe_busy = 1'b0;
        for (int k = 0; k < LAT; k++) pipe_busy = pipe_busy | st[k].valid;
    end

    assign out_valid = st[LAT-1].valid;
    assign out_cmp   = st[LAT-1].cmp;
    assign out_pos   = st[LAT-1].pos;
    assign out_idx   = st[LAT-1].idx;
    assign out_data  = st[LAT-1].data;
endmodule

// File: rtl/vlu_mask_reg.sv
// Per-position enable bits; reset to all ones.
module vlu_mask_reg #(
    parameter int MVL   = 64,
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [POS_W-1:0] wpos,
    input  logic             wbit,
    input  logic [POS_W-1:0] rpos,
    output logic             rbit
);
    logic [MVL-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask_q       <= '1;
        else if (we) mask_q[wpos] <= wbit;
    end

    assign rbit = mask_q[rpos];
endmodule

// File: rtl/vlu_top.sv
module vlu_top
    import vlu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int MVL    = 64,
    parameter int NREG   = 8,
    parameter int IDX_W  = 8,
    parameter int LAT    = 3,
    localparam int REG_W = $clog2(NREG),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              mask_en,
    input  logic [REG_W-1:0]  vd,
    input  logic [REG_W-1:0]  vs1,
    input  logic [REG_W-1:0]  vs2,
    input  logic [DATA_W-1:0] scalar,
    input  logic [LEN_W-1:0]  total_len,
    output logic [REG_W-1:0]  rd_reg_a,
    output logic [REG_W-1:0]  rd_reg_b,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    localparam int POS_W = (MVL > 1) ? $clog2(MVL) : 1;
    localparam int VL_W  = $clog2(MVL + 1);

    seq_state_e        state_q, state_d;
    vop_e              op_q;
    logic              mask_en_q;
    logic [REG_W-1:0]  vd_q, vs1_q, vs2_q;
    logic [DATA_W-1:0] scalar_q;
    logic [VL_W-1:0]   cnt_q;

    logic              seq_load, strip_take, issue;
    logic [VL_W-1:0]   strip_len, vl_q;
    logic [LEN_W-1:0]  base_q, rem_q;

    logic              p_valid, p_cmp, pipe_busy, m_bit;
    logic [POS_W-1:0]  p_pos;
    logic [IDX_W-1:0]  p_idx;
    logic [DATA_W-1:0] p_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_STRIP;
            S_STRIP: begin
                if (strip_len != '0)   state_d = S_ISSUE;
                else if (rem_q == '0)  state_d = S_FIN;
                else                   state_d = S_STRIP;
            end
            S_ISSUE: if (cnt_q == vl_q - VL_W'(1)) state_d = S_DRAIN;
            S_DRAIN: if (!pipe_busy) state_d = (rem_q == '0) ? S_FIN : S_STRIP;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_FIN);
        issue      = (state_q == S_ISSUE);
        strip_take = (state_q == S_STRIP);
        seq_load   = (state_q == S_IDLE) && start;
    end

    // Instruction latch and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_ADD_VV;
            mask_en_q <= 1'b0;
            vd_q      <= '0;
            vs1_q     <= '0;
            vs2_q     <= '0;
            scalar_q  <= '0;
            cnt_q     <= '0;
        end else begin
            if (seq_load) begin
                op_q      <= vop_e'(op);
                mask_en_q <= mask_en;
                vd_q      <= vd;
                vs1_q     <= vs1;
                vs2_q     <= vs2;
                scalar_q  <= scalar;
            end
            if (strip_take)  cnt_q <= '0;
            else if (issue)  cnt_q <= cnt_q + VL_W'(1);
        end
    end

    vlu_strip_seq #(.MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(seq_load), .total_len(total_len),
        .take(strip_take), .strip_len(strip_len), .vl_q(vl_q),
        .base_q(base_q), .rem_q(rem_q)
    );

    assign rd_reg_a = vs1_q;
    assign rd_reg_b = vs2_q;
    assign rd_idx   = IDX_W'(base_q + LEN_W'(cnt_q));

    vlu_lane_pipe #(.DATA_W(DATA_W), .POS_W(POS_W), .IDX_W(IDX_W), .LAT(LAT)) u_lane (
        .clk(clk), .rst_n(rst_n), .in_valid(issue), .in_op(op_q),
        .in_a(rd_data_a), .in_b(rd_data_b), .in_s(scalar_q),
        .in_pos(POS_W'(cnt_q)), .in_idx(rd_idx),
        .out_valid(p_valid), .out_cmp(p_cmp), .out_pos(p_pos),
        .out_idx(p_idx), .out_data(p_data), .pipe_busy(pipe_busy)
    );

    vlu_mask_reg #(.MVL(MVL), .POS_W(POS_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(p_valid && p_cmp), .wpos(p_pos),
        .wbit(p_data[0]), .rpos(p_pos), .rbit(m_bit)
    );

    assign wr_en   = p_valid && !p_cmp && (!mask_en_q || m_bit);
    assign wr_reg  = vd_q;
    assign wr_idx  = p_idx;
    assign wr_data = p_data;
endmodule

// File: rtl/vlu_checker.sv
module vlu_checker
    import vlu_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9,
    parameter int VL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [LEN_W-1:0] base_q,
    input logic [VL_W-1:0]  vl_q,
    input vop_e             op_q
);
    // R1: nothing is written and no completion is flagged while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !done));

    // R2: a start during an active instruction leaves the latched opcode alone
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));

    // R3: each write lands inside the current strip window
    a_r3_idx_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((LEN_W'(wr_idx) >= base_q) &&
                   (LEN_W'(wr_idx) < base_q + LEN_W'(vl_q))));

    // R6: the compare never writes the element store
    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (op_q != OP_CMPNE_VS));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no write in the done cycle
    a_r9_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);
endmodule

bind vlu_top vlu_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .VL_W(VL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_idx(wr_idx), .base_q(base_q), .vl_q(vl_q), .op_q(op_q)
);

// File: tb/tb_vlu_top.sv
module tb_vlu_top;
    localparam int DATA_W = 64;
    localparam int MVL    = 64;
    localparam int NREG   = 8;
    localparam int IDX_W  = 8;
    localparam int LAT    = 3;
    localparam int REG_W  = $clog2(NREG);
    localparam int LEN_W  = IDX_W + 1;
    localparam int NIDX   = 1 << IDX_W;
    localparam int NCASE  = 10;

    typedef struct packed {
        logic [2:0]  op;
        logic        men;
        logic [8:0]  n;
        logic [63:0] s;
    } case_t;

    // op, mask_en, n, scalar
    localparam case_t CASES [NCASE] = '{
        '{3'd0, 1'b0, 9'd5,   64'd0},    // R5 add vv, short single strip
        '{3'd1, 1'b0, 9'd64,  64'd0},    // R5 sub vv, exactly MVL
        '{3'd2, 1'b0, 9'd130, 64'd100},  // R3 leftover 2 then two full strips
        '{3'd4, 1'b0, 9'd128, 64'd3},    // R4 leading zero-length strip
        '{3'd5, 1'b0, 9'd10,  64'd2},    // R6 compare, partial mask update
        '{3'd3, 1'b1, 9'd12,  64'd1},    // R7 masked sub vs
        '{3'd0, 1'b0, 9'd12,  64'd0},    // R7 unmasked ignores mask
        '{3'd5, 1'b0, 9'd70,  64'd0},    // R6 compare over two strips
        '{3'd2, 1'b1, 9'd70,  64'd9},    // R7 masked over two strips
        '{3'd0, 1'b0, 9'd0,   64'd0}     // R4 zero total count
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        op = 3'd0;
    logic              mask_en = 1'b0;
    logic [REG_W-1:0]  vd = REG_W'(3), vs1 = REG_W'(1), vs2 = REG_W'(2);
    logic [DATA_W-1:0] scalar = '0;
    logic [LEN_W-1:0]  total_len = '0;
    logic [REG_W-1:0]  rd_reg_a, rd_reg_b, wr_reg;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [DATA_W-1:0] rd_data_a, rd_data_b, wr_data;
    logic              wr_en, busy, done;

    logic [DATA_W-1:0] rf [NREG][NIDX];
    logic              init_req = 1'b0;
    int                cyc = 0, wr_cnt = 0, first_wr = 0, last_wr = 0;
    int                checks = 0, errors = 0;
    logic [MVL-1:0]    model_mask = '1;

    always #2 clk = ~clk;

    vlu_top #(.DATA_W(DATA_W), .MVL(MVL), .NREG(NREG), .IDX_W(IDX_W), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mask_en(mask_en),
        .vd(vd), .vs1(vs1), .vs2(vs2), .scalar(scalar), .total_len(total_len),
        .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b), .rd_idx(rd_idx),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    function automatic logic [63:0] va(int j);   return 64'(j % 5);            endfunction
    function automatic logic [63:0] vb(int j);   return 64'(j * 7 + 3);        endfunction
    function automatic logic [63:0] vinit(int j); return 64'hD000_0000_0000_0000 | 64'(j); endfunction

    assign rd_data_a = rf[rd_reg_a][rd_idx];
    assign rd_data_b = rf[rd_reg_b][rd_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (init_req) begin
            for (int j = 0; j < NIDX; j++) begin
                rf[1][j] <= va(j);
                rf[2][j] <= vb(j);
                rf[3][j] <= vinit(j);
            end
            wr_cnt <= 0;
        end else if (wr_en) begin
            rf[wr_reg][wr_idx] <= wr_data;
            if (wr_cnt == 0) first_wr <= cyc;
            last_wr <= cyc;
            wr_cnt  <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_op(logic [2:0] o, int j, logic [63:0] s);
        case (o)
            3'd0: return va(j) + vb(j);
            3'd1: return va(j) - vb(j);
            3'd2: return va(j) + s;
            3'd3: return va(j) - s;
            3'd4: return va(j) * s;
            default: return 64'd0;
        endcase
    endfunction

    task automatic run_case(input logic [2:0] o, input bit men, input int n,
                            input logic [63:0] s, input bit poke, input string tag);
        int exp_w = 0, bad = 0, bad_j = -1, guard = 0, done_cyc, r;
        logic [63:0] exp_v, bad_a = 0, bad_e = 0;
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
        op = o; mask_en = men; scalar = s; total_len = LEN_W'(n); start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            op = 3'd1; scalar = 64'd77; start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        done_cyc = cyc;
        chk(done == 1'b1, "R9", {tag, " done seen"}, 64'(done), 64'd1);
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done one cycle"}, 64'(done), 64'd0);
        r = n % MVL;
        for (int j = 0; j < NIDX; j++) begin
            int p;
            exp_v = vinit(j);
            if (j < n) begin
                p = (j < r) ? j : (j - r) % MVL;
                if (o == 3'd5) model_mask[p] = (va(j) != s);
                else if (!men || model_mask[p]) begin
                    exp_v = ref_op(o, j, s);
                    exp_w++;
                end
            end
            if (rf[3][j] !== exp_v) begin
                bad++;
                if (bad_j < 0) begin bad_j = j; bad_a = rf[3][j]; bad_e = exp_v; end
            end
        end
        // R3 R5 R6 R7: whole destination compared, indices >= n untouched
        chk(bad == 0, "R3/R5/R7", {tag, " dest contents"}, bad_a, bad_e);
        chk(wr_cnt == exp_w, "R4", {tag, " write count"}, 64'(wr_cnt), 64'(exp_w));
        if (exp_w > 0)
            chk(done_cyc > last_wr, "R9", {tag, " done after last write"},
                64'(done_cyc), 64'(last_wr + 1));
        if (!men && o != 3'd5 && n > 0 && n <= MVL)
            chk(last_wr - first_wr == n - 1, "R8", {tag, " one element per clock"},
                64'(last_wr - first_wr), 64'(n - 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R1", "reset outputs",
            {61'd0, busy, done, wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NCASE; k++)
            run_case(CASES[k].op, CASES[k].men, int'(CASES[k].n), CASES[k].s, 1'b0,
                     $sformatf("case%0d", k));
        // R2: stray start in mid-flight must not disturb the running add
        run_case(3'd0, 1'b0, 64, 64'd0, 1'b1, "R2 poke");
        // R1: after a fresh reset the mask is all ones again
        @(negedge clk) rst_n = 1'b0;
        model_mask = '1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "second reset outputs",
            {62'd0, busy, done}, 64'd0);
        rst_n = 1'b1;
        run_case(3'd2, 1'b1, 20, 64'd5, 1'b0, "R1 mask ones");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule